// File: doc/BRIEF.md
# Flash Programming Status Tracker

This block is the control side of a small nonvolatile page programmer. A host fills a page buffer with byte writes, usually after issuing a buffer-load command. It then starts either a programming cycle or an erase cycle. The cycle runs for a fixed number of clocks, set by a parameter. When it ends, the page array is updated. The array is modelled in registers and comes out of reset fully erased (every byte FFh).

An 8-bit status word shows four active-high "good" flags:
- ready
- supply good
- last cycle succeeded
- no buffer load pending

While a cycle runs, reads can be used for completion polling:
- During a program cycle, a read of the last loaded address returns the last loaded byte with bit 7 inverted.
- During an erase cycle, every read returns 7Fh.

When the cycle completes, reads return the stored contents again.

A brownout input does two things. It blocks every command for as long as it is asserted. If it is seen at any point during a cycle, that cycle is marked as failed and its result is not committed.

Top module: `flash_prog_status`

## Requirements
- R1: After reset the status word reads 0Fh, every array byte reads FFh, and no cycle is running.
- R2: Status word layout: bit 0 = ready, bit 1 = supply good, bit 2 = last cycle succeeded, bit 3 = no buffer load pending. Bits 7:4 always read 0.
- R3: An accepted buffer-load command drops status bit 3 one clock later. The next accepted program or erase start raises bit 3 again.
- R4: An accepted program start drops bit 0 and bit 2 one clock later. Bit 0 stays low for exactly PROG_CYCLES clocks and then rises. If no brownout was seen during the cycle, bit 2 rises at the same moment and every buffer byte written since the last load command is stored.
- R5: While a program cycle runs, a read of the last loaded address returns the last loaded byte with bit 7 inverted. Reads of any other address return the old stored contents. After the cycle, the new value is returned.
- R6: The polled byte is the one written last in time before the start command, not the byte at the highest address.
- R7: While an erase cycle runs, every read returns 7Fh. After a successful erase, every byte reads FFh.
- R8: While the brownout input is high, buffer-load, byte-write, program and erase commands are ignored. One clock after it rises, status bits 1 and 0 read low. One clock after it falls, they read high again (when no cycle runs).
- R9: A brownout during a cycle does not stop the cycle timer: bit 0 still returns PROG_CYCLES clocks after the start. Bit 2 stays low and the stored contents are unchanged.
- R10: While a cycle runs, buffer-load, byte-write and new start commands are ignored, and the running cycle is not lengthened.
- R11: If program and erase starts arrive in the same clock, the erase is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bod_low_i | input | 1 | Supply below programming level |
| cmd_load_i | input | 1 | Buffer-load command pulse; clears the buffer's written-byte marks |
| cmd_prog_i | input | 1 | Start a programming cycle |
| cmd_erase_i | input | 1 | Start an erase cycle |
| wr_en_i | input | 1 | Byte write into the page buffer |
| wr_addr_i | input | AW | Byte address of the buffer write |
| wr_data_i | input | 8 | Byte to place in the buffer |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | 8 | Array byte, or poll value during a cycle |
| status_o | output | 8 | Status word |

## Verification
The hardest case to reach is a brownout that arrives after a cycle has started and clears before it ends. From the ports, the ready flag then looks normal, and the only signs of the failure are a low success flag and an unchanged array. The stimulus starts a program cycle, raises the brownout input a few clocks in, and drops it well before the timer expires. It then checks the exact clock on which ready returns, the status word, and that the targeted byte still holds its earlier value. A second delicate case is a load, write or start issued mid-cycle. Its absence is shown by the cycle length, by status bit 3, and by which address polls inverted in the following cycle.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int ST_READY  = 0;
    localparam int ST_SUPPLY = 1;
    localparam int ST_OK     = 2;
    localparam int ST_NOLOAD = 3;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    function automatic logic [7:0] poll_flip(input logic [7:0] b);
        return {~b[7], b[6:0]};
    endfunction

endpackage

// File: rtl/fps_cycle_timer.sv
module fps_cycle_timer #(
    parameter  int CYCLES = 16,
    localparam int CW     = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o,
    output logic done_o
);

    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.active) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.active = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = LAST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active_o = tmr_q.active;
    assign done_o   = tmr_q.active && (tmr_q.cnt == '0);

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    assert_end_only_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_q.active) |-> ($past(tmr_q.cnt) == '0));

    assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.active && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));

endmodule

// File: rtl/fps_page_buffer.sv
module fps_page_buffer #(
    parameter  int BYTES = 8,
    localparam int AW    = $clog2(BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  wr_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [7:0]            data_i,
    output logic [BYTES-1:0][7:0] data_o,
    output logic [BYTES-1:0]      valid_o,
    output logic [AW-1:0]         last_addr_o,
    output logic [7:0]            last_data_o
);

    typedef struct packed {
        logic [BYTES-1:0][7:0] data;
        logic [BYTES-1:0]      valid;
        logic [AW-1:0]         last_addr;
        logic [7:0]            last_data;
    } pbuf_t;

    pbuf_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (clear_i) begin
            pb_d.valid = '0;
        end
        if (wr_i) begin
            pb_d.data[addr_i]  = data_i;
            pb_d.valid[addr_i] = 1'b1;
            pb_d.last_addr     = addr_i;
            pb_d.last_data     = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q.data      <= {BYTES{8'hFF}};
            pb_q.valid     <= '0;
            pb_q.last_addr <= '0;
            pb_q.last_data <= '0;
        end else begin
            pb_q <= pb_d;
        end
    end

    assign data_o      = pb_q.data;
    assign valid_o     = pb_q.valid;
    assign last_addr_o = pb_q.last_addr;
    assign last_data_o = pb_q.last_data;

    assert_write_marks_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (valid_o[$past(addr_i)] && last_data_o == $past(data_i)));

    assert_clear_drops_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !wr_i) |=> (valid_o == '0));

endmodule

// File: rtl/fps_flash_page.sv
module fps_flash_page #(
    parameter  int BYTES = 8,
    localparam int AW    = $clog2(BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_prog_i,
    input  logic                  commit_erase_i,
    input  logic [BYTES-1:0][7:0] buf_i,
    input  logic [BYTES-1:0]      valid_i,
    input  logic [AW-1:0]         rd_addr_i,
    output logic [7:0]            rd_data_o
);

    logic [BYTES-1:0][7:0] cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        for (int i = 0; i < BYTES; i++) begin
            if (commit_erase_i) begin
                cell_d[i] = fps_pkg::ERASED_BYTE;
            end else if (commit_prog_i && valid_i[i]) begin
                cell_d[i] = buf_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= {BYTES{fps_pkg::ERASED_BYTE}};
        end else begin
            cell_q <= cell_d;
        end
    end

    assign rd_data_o = cell_q[rd_addr_i];

    assert_cells_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_prog_i && !commit_erase_i) |=> $stable(cell_q));

    assert_single_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_prog_i && commit_erase_i));

endmodule

// File: rtl/flash_prog_status.sv
module flash_prog_status
    import fps_pkg::*;
#(
    parameter  int PAGE_BYTES  = 8,
    parameter  int PROG_CYCLES = 16,
    localparam int AW          = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bod_low_i,
    input  logic          cmd_load_i,
    input  logic          cmd_prog_i,
    input  logic          cmd_erase_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic [7:0]    status_o
);

    typedef struct packed {
        logic          noload;
        logic          ok;
        logic          inhibit;
        logic          bod_seen;
        op_e           op;
        logic [7:0]    poll_data;
        logic [AW-1:0] poll_addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                       tmr_active, tmr_done;
    logic                       blocked, start_erase, start_prog, start_any;
    logic                       buf_clear, buf_wr;
    logic                       commit_prog, commit_erase, end_ok;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0]      buf_valid;
    logic [AW-1:0]              last_addr;
    logic [7:0]                 last_data;
    logic [7:0]                 cell_rd;

    // command gating: brownout or a running cycle blocks everything
    assign blocked     = bod_low_i || ctl_q.inhibit || tmr_active;
    assign start_erase = cmd_erase_i && !blocked;
    assign start_prog  = cmd_prog_i && !cmd_erase_i && !blocked;
    assign start_any   = start_erase || start_prog;
    assign buf_clear   = cmd_load_i && !blocked && !start_any;
    assign buf_wr      = wr_en_i && !blocked && !start_any;

    assign end_ok       = tmr_done && !ctl_q.bod_seen && !bod_low_i;
    assign commit_prog  = end_ok && (ctl_q.op == OP_PROG);
    assign commit_erase = end_ok && (ctl_q.op == OP_ERASE);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.inhibit = bod_low_i;
        if (buf_clear) begin
            ctl_d.noload = 1'b0;
        end
        if (start_any) begin
            ctl_d.noload    = 1'b1;
            ctl_d.ok        = 1'b0;
            ctl_d.bod_seen  = 1'b0;
            ctl_d.op        = start_erase ? OP_ERASE : OP_PROG;
            ctl_d.poll_data = start_erase ? ERASED_BYTE : last_data;
            ctl_d.poll_addr = last_addr;
        end else if (tmr_active) begin
            if (bod_low_i) begin
                ctl_d.bod_seen = 1'b1;
            end
            if (tmr_done) begin
                ctl_d.ok = end_ok;
                ctl_d.op = OP_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.noload    <= 1'b1;
            ctl_q.ok        <= 1'b1;
            ctl_q.inhibit   <= 1'b0;
            ctl_q.bod_seen  <= 1'b0;
            ctl_q.op        <= OP_IDLE;
            ctl_q.poll_data <= '0;
            ctl_q.poll_addr <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    fps_cycle_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_any),
        .active_o (tmr_active),
        .done_o   (tmr_done)
    );

    fps_page_buffer #(
        .BYTES (PAGE_BYTES)
    ) u_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (buf_clear),
        .wr_i        (buf_wr),
        .addr_i      (wr_addr_i),
        .data_i      (wr_data_i),
        .data_o      (buf_data),
        .valid_o     (buf_valid),
        .last_addr_o (last_addr),
        .last_data_o (last_data)
    );

    fps_flash_page #(
        .BYTES (PAGE_BYTES)
    ) u_page (
        .clk            (clk),
        .rst_n          (rst_n),
        .commit_prog_i  (commit_prog),
        .commit_erase_i (commit_erase),
        .buf_i          (buf_data),
        .valid_i        (buf_valid),
        .rd_addr_i      (rd_addr_i),
        .rd_data_o      (cell_rd)
    );

    // read path: poll values replace the array while a cycle runs
    always_comb begin
        rd_data_o = cell_rd;
        if (ctl_q.op == OP_ERASE) begin
            rd_data_o = poll_flip(ctl_q.poll_data);
        end else if (ctl_q.op == OP_PROG && rd_addr_i == ctl_q.poll_addr) begin
            rd_data_o = poll_flip(ctl_q.poll_data);
        end
    end

    always_comb begin
        status_o             = '0;
        status_o[ST_READY]   = !tmr_active && !ctl_q.inhibit;
        status_o[ST_SUPPLY]  = !ctl_q.inhibit;
        status_o[ST_OK]      = ctl_q.ok;
        status_o[ST_NOLOAD]  = ctl_q.noload;
    end

    assert_op_tracks_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.op != OP_IDLE) == tmr_active);

    assert_ok_low_while_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_active |-> !status_o[ST_OK]);

    assert_inhibit_clears_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[ST_SUPPLY] |-> !status_o[ST_READY]);

    assert_start_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_any |=> (status_o[ST_NOLOAD] && !status_o[ST_OK] && !status_o[ST_READY]));

    assert_brownout_fails_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_done && (ctl_q.bod_seen || bod_low_i)) |=> !status_o[ST_OK]);

    assert_erase_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_erase_i && cmd_prog_i && !blocked) |=> (ctl_q.op == OP_ERASE));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:4] == 4'h0);

endmodule

// File: tb/test_flash_prog_status.sv
`timescale 1ns/1ps
module test_flash_prog_status;

    localparam int P = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bod_low = 1'b0;
    logic       cmd_load = 1'b0;
    logic       cmd_prog = 1'b0;
    logic       cmd_erase = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] status;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;
    logic [7:0] mdl [8];

    // {address, data} pairs: load one byte, program, poll, verify
    localparam logic [15:0] VEC [6] = '{
        16'h00_3C, 16'h05_A7, 16'h07_80, 16'h02_7F, 16'h01_00, 16'h06_FF
    };

    always #2.5 clk = ~clk;

    flash_prog_status #(
        .PAGE_BYTES  (8),
        .PROG_CYCLES (P)
    ) i_flash_prog_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .bod_low_i   (bod_low),
        .cmd_load_i  (cmd_load),
        .cmd_prog_i  (cmd_prog),
        .cmd_erase_i (cmd_erase),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .status_o    (status)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_load();
        cmd_load = 1'b1; tick(1); cmd_load = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick(1); wr_en = 1'b0;
    endtask

    task automatic do_prog();
        cmd_prog = 1'b1; tick(1); cmd_prog = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 8; i++) mdl[i] = 8'hFF;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 / R2 reset state
        chk("R1 status after reset", status, 8'h0F);
        rd(3'd4, v);
        chk("R1 erased byte after reset", v, 8'hFF);

        // table walk: R3 R4 R5
        for (int i = 0; i < 6; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = VEC[i][10:8];
            d = VEC[i][7:0];
            do_load();
            chk("R3 load drops bit3", status, 8'h07);
            do_write(a, d);
            do_prog();
            chk("R4 status while busy", status, 8'h0A);
            rd(a, v);
            chk("R5 polled byte inverted", v, {~d[7], d[6:0]});
            tick(P - 1);
            chk("R4 ready still low at P-1", {7'd0, status[0]}, 8'h00);
            tick(1);
            chk("R2 R4 status after cycle", status, 8'h0F);
            mdl[a] = d;
            rd(a, v);
            chk("R5 true value after cycle", v, d);
        end

        // R6: time order decides the polled byte, not address order
        do_load();
        do_write(3'd7, 8'h11);
        do_write(3'd2, 8'hC4);
        do_prog();
        rd(3'd2, v);
        chk("R6 last loaded polled", v, 8'h44);
        rd(3'd7, v);
        chk("R6 highest address not polled", v, mdl[7]);
        tick(P);
        mdl[7] = 8'h11; mdl[2] = 8'hC4;
        rd(3'd7, v);
        chk("R6 high byte stored", v, 8'h11);
        rd(3'd2, v);
        chk("R6 last byte stored", v, 8'hC4);

        // R8: brownout blocks commands and lowers supply and ready
        bod_low = 1'b1;
        tick(1);
        chk("R8 status under brownout", status, 8'h0C);
        do_load();
        do_write(3'd3, 8'h99);
        do_prog();
        cmd_erase = 1'b1; tick(1); cmd_erase = 1'b0;
        chk("R8 commands ignored status", status, 8'h0C);
        bod_low = 1'b0;
        tick(1);
        chk("R8 recovery status", status, 8'h0F);
        rd(3'd3, v);
        chk("R8 array unchanged", v, mdl[3]);

        // R9: brownout mid-cycle
        do_load();
        do_write(3'd4, 8'h5E);
        do_prog();
        tick(3);
        bod_low = 1'b1;
        tick(2);
        bod_low = 1'b0;
        tick(P - 6);
        chk("R9 ready still low at P-1", {7'd0, status[0]}, 8'h00);
        tick(1);
        chk("R9 ready back, success low", status, 8'h0B);
        rd(3'd4, v);
        chk("R9 array untouched", v, mdl[4]);

        // R10: commands during a running cycle are ignored
        do_load();
        do_write(3'd1, 8'h6B);
        do_prog();
        tick(2);
        do_load();
        chk("R10 load ignored while busy", status, 8'h0A);
        do_write(3'd5, 8'h22);
        do_prog();
        tick(P - 6);
        chk("R10 ready still low at P-1", {7'd0, status[0]}, 8'h00);
        tick(1);
        chk("R10 no lengthening", status, 8'h0F);
        mdl[1] = 8'h6B;
        do_prog();
        rd(3'd5, v);
        chk("R10 busy write not recorded", v, mdl[5]);
        rd(3'd1, v);
        chk("R10 poll stays on earlier byte", v, 8'hEB);
        tick(P);

        // R11 / R7: erase wins over program in the same clock
        do_load();
        do_write(3'd2, 8'h5A);
        cmd_prog = 1'b1; cmd_erase = 1'b1;
        tick(1);
        cmd_prog = 1'b0; cmd_erase = 1'b0;
        rd(3'd6, v);
        chk("R7 R11 erase poll value", v, 8'h7F);
        rd(3'd2, v);
        chk("R7 erase poll at loaded addr", v, 8'h7F);
        tick(P);
        chk("R7 status after erase", status, 8'h0F);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            rd(3'(i), e);
            chk("R7 R11 erased byte", e, 8'hFF);
        end

        summary();
    end

endmodule